// File: doc/BRIEF.md
# Byte-Order Correcting DMA Write Path

This block sits on the write side of a network DMA channel. A 16-bit peripheral hands its data over one byte at a time, and the block forwards those bytes into system memory. Each transfer starts with a request that carries a start address, a byte count and a bypass flag. The block forms the memory address by ORing the request address with a channel base-address value. It then issues one or more memory write bursts. Each burst is announced by a start strobe with its address and length and is followed by 16-bit data beats.

The peripheral's 16-bit bus uses the opposite byte order from memory, so the default mode corrects it. In this mode the address and the length are rounded down to even, the two bytes of every halfword are exchanged, and the transfer is cut into bursts of no more than `MAX_BURST` bytes that follow one another in memory. With the bypass flag set, the block leaves the data order alone and sends the whole transfer as one burst, using the exact address and length given. When a transfer finishes, the block raises a single-cycle done pulse and becomes ready for the next request.

Top module: `dma_swap_wr`

## Requirements
- R1: The address of the first burst equals `req_addr | base_addr`, where both values are taken at request acceptance. In swap mode, bit 0 of that address is then cleared.
- R2: With `req_bypass`=1 and a nonzero length, exactly one burst is issued, with the full unmodified length. Beat k carries byte 2k in bits [7:0] and byte 2k+1 in bits [15:8]. For an odd length, the final beat carries the last byte in [7:0] and zero in [15:8].
- R3: In swap mode (`req_bypass`=0), bit 0 of the length is cleared, and exactly that even number of bytes is taken from the input stream. No further byte is accepted for the transfer.
- R4: In swap mode, beat k carries byte 2k+1 in bits [7:0] and byte 2k in bits [15:8].
- R5: In swap mode, bursts are at most `MAX_BURST` (64) bytes long. Every burst except the last is exactly `MAX_BURST` bytes. Each burst starts at the previous burst's address plus the previous burst's length, and the burst lengths add up to the even length.
- R6: A request whose effective length is zero issues no burst. `done` is then raised in the cycle after the request is accepted.
- R7: `done` is high for exactly one cycle, in the cycle after the last beat of the final burst is accepted.
- R8: `req_ready` is high exactly while the block is idle. It is low from the cycle after acceptance through the `done` cycle.
- R9: While `beat_valid` is high and `beat_ready` is low, `beat_valid` stays high and `beat_data` stays unchanged in the next cycle.
- R10: `burst_start` and `beat_valid` are never high in the same cycle. `burst_start` lasts one cycle and comes before the beats of its burst.
- R11: After reset, `req_ready`=1, and `burst_start`, `beat_valid`, `in_ready` and `done` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_addr | input | ADDR_W | Channel base address, ORed into the request address |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken when valid |
| req_addr | input | ADDR_W | Requested start address |
| req_len | input | LEN_W | Requested byte count |
| req_bypass | input | 1 | 1: no byte exchange, single burst |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when valid |
| in_data | input | 8 | Input byte |
| burst_start | output | 1 | One-cycle burst announcement |
| burst_addr | output | ADDR_W | Burst start address, valid with burst_start |
| burst_len | output | LEN_W | Burst byte count, valid with burst_start |
| beat_valid | output | 1 | Data beat valid |
| beat_ready | input | 1 | Memory accepts the beat |
| beat_data | output | 16 | Data beat |
| done | output | 1 | Transfer complete pulse |

## Verification
After a request is accepted, `burst_start` appears in the next cycle. Each beat becomes valid one cycle after the input byte that completes it is accepted. `done` follows the last beat handshake by exactly one cycle, or follows acceptance by one cycle when the length is zero. The bench keeps a behavioural model made of queues of expected bursts, beats and input bytes. At every clock it samples the design's outputs one time unit after the falling edge, when the inputs driven on that edge are stable. It applies the handshakes that the coming rising edge will complete and derives the `done` and `req_ready` values expected in the next cycle from those handshakes.

// File: rtl/dma_swap_pkg.sv
package dma_swap_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_START = 2'd1,
    SEQ_DATA  = 2'd2,
    SEQ_DONE  = 2'd3
  } seq_state_e;

endpackage

// File: rtl/dma_swap_rebase.sv
module dma_swap_rebase #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              swap,
  output logic [ADDR_W-1:0] eff_addr,
  output logic [LEN_W-1:0]  eff_len
);

  logic [ADDR_W-1:0] merged;

  always_comb begin
    merged   = req_addr | base_addr;
    eff_addr = merged;
    eff_len  = req_len;
    if (swap) begin
      eff_addr[0] = 1'b0;
      eff_len[0]  = 1'b0;
    end
  end

endmodule

// File: rtl/dma_swap_seq.sv
module dma_swap_seq
  import dma_swap_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int MAX_BURST = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] eff_addr,
  input  logic [LEN_W-1:0]  eff_len,
  input  logic              swap_in,
  output logic              burst_start,
  output logic [ADDR_W-1:0] burst_addr,
  output logic [LEN_W-1:0]  burst_len,
  output logic              pack_active,
  output logic              pack_need2,
  input  logic              beat_fire,
  output logic              done,
  output logic              swap_mode
);

  localparam logic [LEN_W-1:0] BURST_CAP = LEN_W'(MAX_BURST);
  localparam logic [LEN_W-1:0] ONE_B     = LEN_W'(1);
  localparam logic [LEN_W-1:0] TWO_B     = LEN_W'(2);

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              addr_en;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic              rem_en;
  logic [LEN_W-1:0]  blen_q, blen_d;
  logic              blen_en;
  logic [LEN_W-1:0]  bleft_q, bleft_d;
  logic              bleft_en;
  logic              swap_q, swap_d;
  logic              swap_en;
  logic [LEN_W-1:0]  cut_len;
  logic [LEN_W-1:0]  step;
  logic [LEN_W-1:0]  bleft_nxt;

  always_comb begin
    cut_len   = (swap_q && (rem_q > BURST_CAP)) ? BURST_CAP : rem_q;
    step      = (bleft_q >= TWO_B) ? TWO_B : ONE_B;
    bleft_nxt = bleft_q - step;

    state_d  = state_q;
    addr_d   = addr_q;
    addr_en  = 1'b0;
    rem_d    = rem_q;
    rem_en   = 1'b0;
    blen_d   = blen_q;
    blen_en  = 1'b0;
    bleft_d  = bleft_q;
    bleft_en = 1'b0;
    swap_d   = swap_q;
    swap_en  = 1'b0;

    case (state_q)
      SEQ_IDLE: begin
        if (req_valid) begin
          addr_en = 1'b1;
          addr_d  = eff_addr;
          rem_en  = 1'b1;
          rem_d   = eff_len;
          swap_en = 1'b1;
          swap_d  = swap_in;
          state_d = (eff_len == '0) ? SEQ_DONE : SEQ_START;
        end
      end
      SEQ_START: begin
        blen_en  = 1'b1;
        blen_d   = cut_len;
        bleft_en = 1'b1;
        bleft_d  = cut_len;
        state_d  = SEQ_DATA;
      end
      SEQ_DATA: begin
        if (beat_fire) begin
          bleft_en = 1'b1;
          bleft_d  = bleft_nxt;
          if (bleft_nxt == '0) begin
            rem_en  = 1'b1;
            rem_d   = rem_q - blen_q;
            addr_en = 1'b1;
            addr_d  = addr_q + ADDR_W'(blen_q);
            state_d = (rem_q == blen_q) ? SEQ_DONE : SEQ_START;
          end
        end
      end
      SEQ_DONE: begin
        state_d = SEQ_IDLE;
      end
      default: begin
        state_d = SEQ_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      addr_q  <= '0;
      rem_q   <= '0;
      blen_q  <= '0;
      bleft_q <= '0;
      swap_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (addr_en)  addr_q  <= addr_d;
      if (rem_en)   rem_q   <= rem_d;
      if (blen_en)  blen_q  <= blen_d;
      if (bleft_en) bleft_q <= bleft_d;
      if (swap_en)  swap_q  <= swap_d;
    end
  end

  assign req_ready   = (state_q == SEQ_IDLE);
  assign burst_start = (state_q == SEQ_START);
  assign burst_addr  = addr_q;
  assign burst_len   = cut_len;
  assign pack_active = (state_q == SEQ_DATA);
  assign pack_need2  = (bleft_q >= TWO_B);
  assign done        = (state_q == SEQ_DONE);
  assign swap_mode   = swap_q;

endmodule

// File: rtl/dma_swap_pack.sv
module dma_swap_pack #(
  parameter int LANE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                active,
  input  logic                need2,
  input  logic                swap,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [LANE_W-1:0]   in_data,
  output logic                beat_valid,
  input  logic                beat_ready,
  output logic [2*LANE_W-1:0] beat_data
);

  localparam int BEAT_W = 2 * LANE_W;

  logic [1:0]        cnt_q, cnt_d;
  logic [BEAT_W-1:0] hold_q, hold_d;
  logic              hold_en;
  logic              full;
  logic              in_fire;
  logic              out_fire;
  logic              hi_lane;

  always_comb begin
    full     = (cnt_q == (need2 ? 2'd2 : 2'd1));
    in_ready = active && !full;
    in_fire  = in_valid && in_ready;
    out_fire = active && full && beat_ready;
    hi_lane  = swap ? (cnt_q == 2'd0) : (cnt_q == 2'd1);

    hold_d  = hold_q;
    cnt_d   = cnt_q;
    hold_en = 1'b0;
    if (out_fire) begin
      hold_en = 1'b1;
      hold_d  = '0;
      cnt_d   = 2'd0;
    end else if (in_fire) begin
      hold_en = 1'b1;
      cnt_d   = cnt_q + 2'd1;
      if (hi_lane) hold_d[BEAT_W-1:LANE_W] = in_data;
      else         hold_d[LANE_W-1:0]      = in_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= 2'd0;
      hold_q <= '0;
    end else if (hold_en) begin
      cnt_q  <= cnt_d;
      hold_q <= hold_d;
    end
  end

  assign beat_valid = active && full;
  assign beat_data  = hold_q;

endmodule

// File: rtl/dma_swap_wr.sv
module dma_swap_wr #(
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 16,
  parameter int MAX_BURST   = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_bypass,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  output logic              burst_start,
  output logic [ADDR_W-1:0] burst_addr,
  output logic [LEN_W-1:0]  burst_len,
  output logic              beat_valid,
  input  logic              beat_ready,
  output logic [15:0]       beat_data,
  output logic              done
);

  logic              rst_sync_n;
  logic              swap_req;
  logic              swap_mode;
  logic [ADDR_W-1:0] eff_addr;
  logic [LEN_W-1:0]  eff_len;
  logic              pack_active;
  logic              pack_need2;
  logic              beat_fire;

  generate
    if (SYNC_STAGES < 2) begin : g_sync1
      logic sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 1'b0;
        else        sync_q <= 1'b1;
      end
      assign rst_sync_n = sync_q;
    end else begin : g_syncn
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
      end
      assign rst_sync_n = sync_q[SYNC_STAGES-1];
    end
  endgenerate

  assign swap_req  = !req_bypass;
  assign beat_fire = beat_valid && beat_ready;

  dma_swap_rebase #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W)
  ) u_rebase (
    .req_addr  (req_addr),
    .base_addr (base_addr),
    .req_len   (req_len),
    .swap      (swap_req),
    .eff_addr  (eff_addr),
    .eff_len   (eff_len)
  );

  dma_swap_seq #(
    .ADDR_W    (ADDR_W),
    .LEN_W     (LEN_W),
    .MAX_BURST (MAX_BURST)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .eff_addr    (eff_addr),
    .eff_len     (eff_len),
    .swap_in     (swap_req),
    .burst_start (burst_start),
    .burst_addr  (burst_addr),
    .burst_len   (burst_len),
    .pack_active (pack_active),
    .pack_need2  (pack_need2),
    .beat_fire   (beat_fire),
    .done        (done),
    .swap_mode   (swap_mode)
  );

  dma_swap_pack #(
    .LANE_W (8)
  ) u_pack (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .active     (pack_active),
    .need2      (pack_need2),
    .swap       (swap_mode),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_data    (in_data),
    .beat_valid (beat_valid),
    .beat_ready (beat_ready),
    .beat_data  (beat_data)
  );

endmodule

// File: rtl/dma_swap_wr_chk.sv
module dma_swap_wr_chk #(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int MAX_BURST = 64
) (
  input logic              clk,
  input logic              rst_ok,
  input logic              req_ready,
  input logic              in_ready,
  input logic              burst_start,
  input logic [ADDR_W-1:0] burst_addr,
  input logic [LEN_W-1:0]  burst_len,
  input logic              beat_valid,
  input logic              beat_ready,
  input logic [15:0]       beat_data,
  input logic              done,
  input logic              swap_mode
);

  // R9
  beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (beat_valid && !beat_ready) |=> (beat_valid && $stable(beat_data)));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    done |=> !done);

  // R10
  start_alone_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    burst_start |-> !beat_valid);

  // R10
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    burst_start |=> !burst_start);

  // R8
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (burst_start || beat_valid || in_ready || done) |-> !req_ready);

  // R5
  swap_burst_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (burst_start && swap_mode) |->
      ((burst_len <= LEN_W'(MAX_BURST)) && !burst_len[0] && !burst_addr[0]));

  // R6
  no_empty_burst_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    burst_start |-> (burst_len != '0));

endmodule

bind dma_swap_wr dma_swap_wr_chk #(
  .ADDR_W    (ADDR_W),
  .LEN_W     (LEN_W),
  .MAX_BURST (MAX_BURST)
) u_chk (
  .clk         (clk),
  .rst_ok      (rst_sync_n),
  .req_ready   (req_ready),
  .in_ready    (in_ready),
  .burst_start (burst_start),
  .burst_addr  (burst_addr),
  .burst_len   (burst_len),
  .beat_valid  (beat_valid),
  .beat_ready  (beat_ready),
  .beat_data   (beat_data),
  .done        (done),
  .swap_mode   (swap_mode)
);

// File: tb/test_dma_swap_wr.sv
`timescale 1ns/1ps
module test_dma_swap_wr;

  logic        clk;
  logic        rst_n;
  logic [31:0] base_addr;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_addr;
  logic [15:0] req_len;
  logic        req_bypass;
  logic        in_valid;
  logic        in_ready;
  logic [7:0]  in_data;
  logic        burst_start;
  logic [31:0] burst_addr;
  logic [15:0] burst_len;
  logic        beat_valid;
  logic        beat_ready;
  logic [15:0] beat_data;
  logic        done;

  dma_swap_wr i_dma_swap_wr (
    .clk         (clk),
    .rst_n       (rst_n),
    .base_addr   (base_addr),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_addr    (req_addr),
    .req_len     (req_len),
    .req_bypass  (req_bypass),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_data     (in_data),
    .burst_start (burst_start),
    .burst_addr  (burst_addr),
    .burst_len   (burst_len),
    .beat_valid  (beat_valid),
    .beat_ready  (beat_ready),
    .beat_data   (beat_data),
    .done        (done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  bit mon_en  = 0;
  bit req_pend = 0;
  bit bp_en   = 0;
  bit gap_en  = 0;
  logic [7:0] t_seed;

  logic [7:0]  feed[$];
  logic [31:0] eb_addr[$];
  int          eb_len[$];
  logic [15:0] e_beat[$];
  logic [7:0]  bq[$];
  string       burst_tag;
  string       data_tag;

  bit          m_busy = 0;
  bit          m_due  = 0;
  bit          m_next = 0;
  string       m_due_tag  = "R7";
  string       m_next_tag = "R7";
  bit          hold_prev = 0;
  logic [15:0] hold_data;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_accept();
    logic [31:0] a;
    int          l;
    bit          swp;
    swp = !req_bypass;
    a   = req_addr | base_addr;
    l   = int'(req_len);
    if (swp) begin
      a[0] = 1'b0;
      l    = l & ~1;
    end
    bq.delete();
    for (int k = 0; k < l; k++) begin
      bq.push_back(8'(t_seed + 8'(k * 37)));
      feed.push_back(8'(t_seed + 8'(k * 37)));
    end
    burst_tag = swp ? "R5" : "R2";
    data_tag  = swp ? "R4" : "R2";
    if (l == 0) begin
      m_next     = 1'b1;
      m_next_tag = "R6";
    end else if (!swp) begin
      eb_addr.push_back(a);
      eb_len.push_back(l);
      for (int k = 0; k < l; k += 2)
        e_beat.push_back({(k + 1 < l) ? bq[k+1] : 8'h00, bq[k]});
    end else begin
      int          rem;
      logic [31:0] aa;
      rem = l;
      aa  = a;
      while (rem > 0) begin
        int n;
        n = (rem > 64) ? 64 : rem;
        eb_addr.push_back(aa);
        eb_len.push_back(n);
        aa  = aa + 32'(n);
        rem = rem - n;
      end
      for (int k = 0; k < l; k += 2)
        e_beat.push_back({bq[k], bq[k+1]});
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    in_valid   = !(gap_en && (cyc % 4 == 1));
    in_data    = (feed.size() > 0) ? feed[0] : 8'hEE;
    beat_ready = !(bp_en && (cyc % 3 == 0));
    req_valid  = req_pend;
    #1;
    if (mon_en) begin
      check(req_ready === !m_busy, "R8", "req_ready", req_ready, !m_busy);
      check(done === m_due, m_due_tag, "done", done, m_due);
      check(!(burst_start && beat_valid), "R10", "start with beat", 1, 0);
      if (hold_prev) begin
        check(beat_valid === 1'b1, "R9", "beat_valid held", beat_valid, 1);
        check(beat_data === hold_data, "R9", "beat_data held", beat_data, hold_data);
      end
      hold_prev = beat_valid && !beat_ready;
      hold_data = beat_data;
      if (burst_start) begin
        if (eb_addr.size() == 0) begin
          check(1'b0, "R6", "unexpected burst_start", 1, 0);
        end else begin
          check(burst_addr === eb_addr[0], "R1", "burst_addr", burst_addr, eb_addr[0]);
          check(int'(burst_len) == eb_len[0], burst_tag, "burst_len", burst_len, eb_len[0]);
          void'(eb_addr.pop_front());
          void'(eb_len.pop_front());
        end
      end
      if (beat_valid && beat_ready) begin
        if (e_beat.size() == 0) begin
          check(1'b0, data_tag, "unexpected beat", beat_data, 0);
        end else begin
          check(beat_data === e_beat[0], data_tag, "beat_data", beat_data, e_beat[0]);
          void'(e_beat.pop_front());
          if (e_beat.size() == 0 && eb_addr.size() == 0) begin
            m_next     = 1'b1;
            m_next_tag = "R7";
          end
        end
      end
      if (in_valid && in_ready) begin
        if (feed.size() == 0) check(1'b0, "R3", "extra byte taken", 1, 0);
        else void'(feed.pop_front());
      end
      if (m_due) m_busy = 1'b0;
      if (req_valid && req_ready) begin
        model_accept();
        m_busy   = 1'b1;
        req_pend = 1'b0;
      end
      m_due      = m_next;
      m_due_tag  = m_next_tag;
      m_next     = 1'b0;
    end
  end

  task automatic run_req(input logic [31:0] addr, input logic [15:0] len,
                         input bit byp, input logic [31:0] base,
                         input logic [7:0] seed, input bit bp, input bit gap);
    @(posedge clk);
    req_addr   = addr;
    req_len    = len;
    req_bypass = byp;
    base_addr  = base;
    t_seed     = seed;
    bp_en      = bp;
    gap_en     = gap;
    req_pend   = 1'b1;
    while (req_pend) @(posedge clk);
    while (m_busy) @(posedge clk);
    repeat (2) @(posedge clk);
    check(feed.size() == 0 && e_beat.size() == 0 && eb_addr.size() == 0,
          "R3", "leftover expectations", feed.size() + e_beat.size(), 0);
  endtask

  initial begin
    rst_n      = 1'b0;
    base_addr  = '0;
    req_addr   = '0;
    req_len    = '0;
    req_bypass = 1'b0;
    t_seed     = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    // R11 reset state
    check(req_ready === 1'b1, "R11", "req_ready", req_ready, 1);
    check(burst_start === 1'b0, "R11", "burst_start", burst_start, 0);
    check(beat_valid === 1'b0, "R11", "beat_valid", beat_valid, 0);
    check(in_ready === 1'b0, "R11", "in_ready", in_ready, 0);
    check(done === 1'b0, "R11", "done", done, 0);
    mon_en = 1'b1;

    run_req(32'h0000_0013, 16'd5,   1'b1, 32'h4000_0000, 8'h03, 1'b0, 1'b0); // R1 R2 odd
    run_req(32'h0000_0021, 16'd37,  1'b0, 32'h8000_0000, 8'h11, 1'b0, 1'b0); // R3 R4
    run_req(32'h0000_1000, 16'd200, 1'b0, 32'h0000_0000, 8'h5A, 1'b1, 1'b0); // R5 R9
    run_req(32'h0000_0040, 16'd1,   1'b0, 32'h0000_0000, 8'h77, 1'b0, 1'b0); // R6 swap
    run_req(32'h0000_0040, 16'd0,   1'b1, 32'h0000_0000, 8'h78, 1'b0, 1'b0); // R6 bypass
    run_req(32'h0000_2001, 16'd150, 1'b1, 32'h0100_0000, 8'hC3, 1'b1, 1'b1); // R2 long
    run_req(32'h0000_0003, 16'd128, 1'b0, 32'h0100_0000, 8'h29, 1'b0, 1'b1); // R5 exact
    run_req(32'h0000_0007, 16'd1,   1'b1, 32'h0000_0030, 8'hF0, 1'b1, 1'b0); // R2 one byte
    run_req(32'h0000_0100, 16'd66,  1'b0, 32'h0000_0000, 8'h90, 1'b1, 1'b1); // R5 R7

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule